// File: doc/BRIEF.md
# Processor Clock, Reset and Ready Generator

This block derives the processor-side timing signals from one fast sampling clock. A pair of source strobes, one internal and one external, each mark one period of the fast source. A select input picks which strobe drives the generator. The selected strobe is sent out unchanged as the oscillator output. It also advances a modulo-3 counter. That counter produces a processor clock at one third of the source rate with a one-in-three high time, and a peripheral clock at one sixth of the source rate with an even duty cycle. All division is done with clock enables, so every register runs on the single fast clock.

The block also conditions two housekeeping signals. An active-low power-good input produces an active-high reset. The reset asserts at once and releases in step with the processor clock. A ready output merges two request/enable pairs and is retimed on processor clock falling edges. It passes through either one or two retiming stages, chosen by an active-low stage-select input.

Top module: `clk_rst_rdy_gen`

## Requirements
- R1: While reset input is low, pclk_o is 0 and clk_o is 1. After release, clk_o is high for exactly one of every three selected source strobes. A falling edge of clk_o is the strobe that moves it from high to low.
- R2: pclk_o toggles on each strobe on which clk_o rises (every third strobe), giving a period of six strobes with three high and three low. The first toggle after reset takes it to 1.
- R3: osc_o equals the currently selected strobe in the same cycle.
- R4: With src_sel_i low the internal strobe int_tick_i is used. With it high the external strobe ext_tick_i is used. Strobes on the unselected input leave clk_o, pclk_o and osc_o unchanged.
- R5: reset_o is 1 as soon as rst_n_i is low, without waiting for a strobe.
- R6: After rst_n_i goes high, reset_o falls on the second clk_o falling edge, and stays low after that.
- R7: The ready request is (rdy1_i AND NOT aen1_n_i) OR (rdy2_i AND NOT aen2_n_i). ready_o changes only on clk_o falling edges.
- R8: With sync_sel_n_i high, a new ready request appears at the first clk_o falling edge that samples it. With sync_sel_n_i low it appears one clk_o falling edge later (two stages).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_n_i | input | 1 | Active-low power-good reset input, asynchronous |
| src_sel_i | input | 1 | Source select: 0 internal strobe, 1 external strobe |
| int_tick_i | input | 1 | Internal source strobe, one per source period |
| ext_tick_i | input | 1 | External source strobe, one per source period |
| rdy1_i | input | 1 | Ready request, source 1, active high |
| aen1_n_i | input | 1 | Enable for source 1, active low |
| rdy2_i | input | 1 | Ready request, source 2, active high |
| aen2_n_i | input | 1 | Enable for source 2, active low |
| sync_sel_n_i | input | 1 | Low selects two ready retiming stages, high one |
| osc_o | output | 1 | Selected source strobe |
| clk_o | output | 1 | Processor clock, source/3, 33% duty |
| pclk_o | output | 1 | Peripheral clock, source/6, 50% duty |
| reset_o | output | 1 | Active-high processor reset |
| ready_o | output | 1 | Retimed ready |

## Verification
The hardest case to reach is the exact edge on which ready_o moves. The result depends on the phase of the processor clock when the request changes, and on how many retiming stages are active. The bench keeps its own count of strobes since reset and the clock phase that count implies. It changes the request just after a known falling edge, then checks at the strobes on both sides of the next falling edge and the one after it, in each stage mode. Reset release is checked the same way, against the second falling edge.

// File: rtl/clk_rst_rdy_gen.sv
module clk_rst_rdy_gen (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic src_sel_i,
  input  logic int_tick_i,
  input  logic ext_tick_i,
  input  logic rdy1_i,
  input  logic aen1_n_i,
  input  logic rdy2_i,
  input  logic aen2_n_i,
  input  logic sync_sel_n_i,
  output logic osc_o,
  output logic clk_o,
  output logic pclk_o,
  output logic reset_o,
  output logic ready_o
);

  logic       tick;
  logic [1:0] ph;
  logic       pclk_q;
  logic       fall, rise;
  logic [1:0] rst_sh;
  logic       rdy_req, rdy_s1, rdy_s2;

  assign tick    = src_sel_i ? ext_tick_i : int_tick_i;
  assign osc_o   = tick;
  assign fall    = tick && (ph == 2'd0);
  assign rise    = tick && (ph == 2'd2);
  assign clk_o   = (ph == 2'd0);
  assign pclk_o  = pclk_q;
  assign reset_o = ~rst_sh[1];
  assign rdy_req = (rdy1_i & ~aen1_n_i) | (rdy2_i & ~aen2_n_i);
  assign ready_o = sync_sel_n_i ? rdy_s1 : rdy_s2;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ph     <= 2'd0;
      pclk_q <= 1'b0;
    end else if (tick) begin
      ph <= (ph == 2'd2) ? 2'd0 : ph + 2'd1;
      if (rise) pclk_q <= ~pclk_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_sh <= 2'b00;
      rdy_s1 <= 1'b0;
      rdy_s2 <= 1'b0;
    end else if (fall) begin
      rst_sh <= {rst_sh[0], 1'b1};
      rdy_s1 <= rdy_req;
      rdy_s2 <= rdy_s1;
    end
  end

  assert_clk_high_one_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (tick && clk_o) |=> !clk_o);

  assert_pclk_on_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !$stable(pclk_o) |-> $rose(clk_o));

  assert_reset_release_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(reset_o) |-> $fell(clk_o));

  assert_reset_stays_low_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !reset_o |=> !reset_o);

  assert_ready_on_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!$stable(ready_o) && $stable(sync_sel_n_i)) |-> $fell(clk_o));

endmodule

// File: tb/tb_clk_rst_rdy_gen.sv
module tb_clk_rst_rdy_gen;
  logic clk = 0;
  logic rst_n = 0;
  logic src_sel = 0, int_tick = 1, ext_tick = 0;
  logic rdy1 = 0, aen1_n = 1, rdy2 = 0, aen2_n = 1, sync_sel_n = 1;
  logic osc, clk_o, pclk, reset_o, ready;
  int checks = 0, errors = 0, n = 0;
  bit done = 0;

  clk_rst_rdy_gen dut (
    .clk_i(clk), .rst_n_i(rst_n), .src_sel_i(src_sel), .int_tick_i(int_tick),
    .ext_tick_i(ext_tick), .rdy1_i(rdy1), .aen1_n_i(aen1_n), .rdy2_i(rdy2),
    .aen2_n_i(aen2_n), .sync_sel_n_i(sync_sel_n), .osc_o(osc), .clk_o(clk_o),
    .pclk_o(pclk), .reset_o(reset_o), .ready_o(ready));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (n=%0d)", req, act, exp, n);
    end
  endtask

  task automatic step(input int k);
    for (int i = 0; i < k; i++) begin
      @(posedge clk); n++; @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; #1;
    chk("R5", reset_o, 1'b1);
    chk("R1", clk_o, 1'b1);
    chk("R2", pclk, 1'b0);
    @(negedge clk); rst_n = 1; n = 0;
  endtask

  task automatic test_divide();
    do_reset();
    for (int i = 0; i < 18; i++) begin
      step(1);
      chk("R1", clk_o, (n % 3) == 0);
      chk("R2", pclk, ((n / 3) % 2) == 1);
      chk("R3", osc, int_tick);
    end
  endtask

  task automatic test_reset_release();
    do_reset();
    step(3);
    chk("R6", reset_o, 1'b1);
    step(1);
    chk("R6", reset_o, 1'b0);
    step(6);
    chk("R6", reset_o, 1'b0);
  endtask

  task automatic test_select();
    logic c, p;
    do_reset();
    step(2);
    src_sel = 1; ext_tick = 0; #1;
    c = clk_o; p = pclk;
    chk("R3", osc, 1'b0);
    step(5);
    chk("R4", clk_o, c);
    chk("R4", pclk, p);
    chk("R4", osc, 1'b0);
    ext_tick = 1; #1;
    chk("R3", osc, 1'b1);
    step(1);
    chk("R4", clk_o, 1'b1);
    step(1);
    chk("R4", clk_o, 1'b0);
    src_sel = 0; ext_tick = 0;
  endtask

  task automatic test_ready();
    do_reset();
    sync_sel_n = 1;
    step(1);
    rdy1 = 1; aen1_n = 1;
    step(3);
    chk("R7", ready, 1'b0);
    aen1_n = 0;
    step(2);
    chk("R7", ready, 1'b0);
    step(1);
    chk("R8", ready, 1'b1);
    rdy1 = 0; rdy2 = 1; aen2_n = 0;
    step(3);
    chk("R7", ready, 1'b1);
    rdy2 = 0;
    step(2);
    chk("R7", ready, 1'b1);
    step(1);
    chk("R8", ready, 1'b0);
    sync_sel_n = 0;
    step(3);
    rdy2 = 1;
    step(3);
    chk("R8", ready, 1'b0);
    step(2);
    chk("R8", ready, 1'b0);
    step(1);
    chk("R8", ready, 1'b1);
    rdy2 = 0; aen2_n = 1; sync_sel_n = 1;
  endtask

  initial begin
    test_divide();
    test_reset_release();
    test_select();
    test_ready();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule